// File: doc/BRIEF.md
# Chained Presettable Synchronous Binary Counter

This block is a synchronous up-counter made of identical 4-bit stages. Every stage holds four flip-flops that share one clock edge. A stage can be cleared at once, loaded in parallel on the next edge, incremented, or left unchanged. Each stage has two active-high enables. The "parallel" enable only gates counting. The "trickle" enable gates counting and also qualifies the stage's carry.

The wrapper builds a counter of WIDTH bits, where WIDTH must be a multiple of 4. The carry of each stage drives the trickle enable of the stage above it. Clock, clear, load and the parallel enable go to every stage. The whole counter therefore advances on one edge, with no gating between the stages. The final carry is brought out so that further counters can be chained on.

Top module: `sync_bin_counter_chain`

## Requirements
- R1: While `clr_n` is low, `q` is zero. This does not wait for a clock edge, and the levels of `load_n`, `din` and the enables make no difference.
- R2: When `load_n` is low at a rising edge (with `clr_n` high), `q` takes the value of `din`, whatever the enable levels are.
- R3: When `load_n`, `cnt_en_p` and `cnt_en_t` are all high at a rising edge, `q` increases by one modulo 2^WIDTH.
- R4: When `load_n` is high and either enable is low at a rising edge, `q` keeps its value.
- R5: `carry_out` is high exactly when `cnt_en_t` is high and every bit of `q` is 1. `cnt_en_p` has no effect on it.
- R6: Counting from all ones gives zero. A counter preset to all ones minus 3 counts +1, +2, all ones, 0, 1, 2, and then holds when an enable goes low.
- R7: Each 4-bit stage above the lowest advances only on an edge where every lower stage reads 15 and the counter is counting. All stages update on the same edge.
- R8: Changes on `load_n`, `din`, `cnt_en_p` or `cnt_en_t` between rising edges leave `q` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_p | input | 1 | Parallel count enable, shared by all stages |
| cnt_en_t | input | 1 | Trickle count enable of the lowest stage; also qualifies the carry |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Counter state |
| carry_out | output | 1 | High when `cnt_en_t` is high and `q` is all ones |

## Verification
The clocked properties assume that the synchronous inputs are stable around each rising edge. They also assume that `clr_n` takes effect only between edges, so that one clock edge never sees a clear and a load or count at once. To meet this, the stimulus changes the synchronous inputs only on falling edges. It drops or raises `clr_n` a short delay after a falling edge. The check on mid-cycle input changes toggles the controls well away from the rising edge and then puts them back.

// File: rtl/bincnt_pkg.sv
package bincnt_pkg;
  localparam int unsigned STAGE_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } cnt_op_t;
endpackage

// File: rtl/bincnt_mode_dec.sv
module bincnt_mode_dec
  import bincnt_pkg::*;
(
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_t op
);
  // Load outranks both enables; counting needs both enables.
  always_comb begin
    if (!load_n)            op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
  end
endmodule

// File: rtl/bincnt_stage.sv
module bincnt_stage
  import bincnt_pkg::*;
#(
  parameter int unsigned W = STAGE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rco
);
  localparam logic [W-1:0] ONE = W'(1);

  cnt_op_t      op;
  logic [W-1:0] q_nxt;

  bincnt_mode_dec u_dec (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  always_comb begin
    unique case (op)
      OP_LOAD:  q_nxt = d;
      OP_COUNT: q_nxt = q + ONE;
      default:  q_nxt = q;
    endcase
  end

  // Clear is part of the block's function and acts without a clock.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_nxt;
  end

  // Look-ahead carry: only the trickle enable qualifies it.
  assign rco = en_t & (&q);
endmodule

// File: rtl/sync_bin_counter_chain.sv
module sync_bin_counter_chain
  import bincnt_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             cnt_en_p,
  input  logic             cnt_en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  localparam int unsigned NSTAGES = WIDTH / STAGE_W;

  logic [NSTAGES:0] t_chain;

  assign t_chain[0] = cnt_en_t;

  for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
    bincnt_stage #(.W(STAGE_W)) u_stage (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (cnt_en_p),
      .en_t   (t_chain[s]),
      .d      (din[s*STAGE_W +: STAGE_W]),
      .q      (q[s*STAGE_W +: STAGE_W]),
      .rco    (t_chain[s+1])
    );
  end

  assign carry_out = t_chain[NSTAGES];
endmodule

// File: rtl/bincnt_chain_chk.sv
module bincnt_chain_chk #(
  parameter int unsigned WIDTH = 12
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             cnt_en_p,
  input logic             cnt_en_t,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry_out
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // R1: clear holds the state at zero
  always @(negedge clk) begin
    if (clr_n === 1'b0) begin
      a_clear_zero_r1: assert (q == '0);
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  p_count_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en_p && cnt_en_t) |=> q == $past(q) + ONE);

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(q));

  p_carry_high_r5: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (cnt_en_t && (&q)));

  p_carry_full_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (cnt_en_t && (&q)) |-> carry_out);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en_p && carry_out) |=> q == '0);

  p_upper_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && q[3:0] != 4'hF) |=> $stable(q[WIDTH-1:4]));
endmodule

bind sync_bin_counter_chain bincnt_chain_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .cnt_en_p  (cnt_en_p),
  .cnt_en_t  (cnt_en_t),
  .din       (din),
  .q         (q),
  .carry_out (carry_out)
);

// File: tb/test_sync_bin_counter_chain.sv
`timescale 1ns/1ps
module test_sync_bin_counter_chain;
  localparam int unsigned W = 12;
  localparam logic [W-1:0] ALL1 = '1;

  typedef struct {
    logic [W-1:0] q;
    logic         c;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         load_n = 1'b1;
  logic         en_p = 1'b0;
  logic         en_t = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         carry;

  int unsigned  n_run = 0;
  int unsigned  n_fail = 0;
  logic [W-1:0] model = '0;
  exp_t         sb[$];
  bit           done = 1'b0;

  always #4 clk = ~clk;

  sync_bin_counter_chain #(.WIDTH(W)) i_sync_bin_counter_chain (
    .clk (clk), .clr_n (clr_n), .load_n (load_n), .cnt_en_p (en_p),
    .cnt_en_t (en_t), .din (din), .q (q), .carry_out (carry)
  );

  task automatic check(string tag, logic [W-1:0] aq, logic [W-1:0] eq,
                       logic ac, logic ec);
    n_run++;
    if (aq !== eq || ac !== ec) begin
      n_fail++;
      $display("FAIL %s q=%h carry=%b expected q=%h carry=%b", tag, aq, ac, eq, ec);
    end
  endtask

  // Monitor: compares after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, q, e.q, carry, e.c);
    end
  end

  // Driver: sets inputs on a falling edge, queues the post-edge result
  task automatic step(logic ld, logic p, logic t, logic [W-1:0] d);
    exp_t e;
    string tag;
    @(negedge clk);
    load_n = ld; en_p = p; en_t = t; din = d;
    if (!ld) begin
      tag = "R2"; model = d;
    end else if (p && t) begin
      tag = (model == ALL1) ? "R6" : (model[3:0] == 4'hF) ? "R7" : "R3";
      model = model + 1'b1;
    end else begin
      tag = "R4";
    end
    if (model == ALL1) tag = {tag, "/R5"};
    e.q = model; e.c = t && (model == ALL1); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_clear();
    @(negedge clk);
    #2;
    load_n = 1'b0; din = W'($urandom); en_p = 1'b1; en_t = 1'b1;
    clr_n = 1'b0;
    #1;
    check("R1", q, '0, carry, 1'b0);
    @(posedge clk);
    #2;
    check("R1", q, '0, carry, 1'b0);
    model = '0;
    @(negedge clk);
    load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    #2 clr_n = 1'b1;
  endtask

  task automatic mid_cycle_toggle();
    logic [W-1:0] q0;
    @(negedge clk);
    q0 = q;
    load_n = 1'b0; din = ~q0; en_p = 1'b1; en_t = 1'b1;
    #1;
    check("R8", q, q0, carry, (q0 == ALL1));
    load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    #1;
    check("R8", q, q0, carry, 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #3;
    check("R1", q, '0, carry, 1'b0);
    @(negedge clk);
    #2 clr_n = 1'b1;

    // R6 sequence: preset, count through wrap, then hold
    step(1'b0, 1'b0, 1'b0, ALL1 - 3);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, '0);
    step(1'b1, 1'b0, 1'b1, '0);
    step(1'b1, 1'b1, 1'b0, '0);

    // R5: carry at all ones depends on trickle enable only
    step(1'b0, 1'b1, 1'b1, ALL1);
    step(1'b1, 1'b0, 1'b1, '0);
    step(1'b1, 1'b0, 1'b0, '0);
    step(1'b1, 1'b1, 1'b0, '0);

    // R7: nibble carries across stage boundaries
    step(1'b0, 1'b0, 1'b0, 12'h0FE);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, '0);
    step(1'b0, 1'b1, 1'b1, 12'h00E);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, '0);

    // R1 mid-cycle clear, then R8 mid-cycle input changes
    do_clear();
    step(1'b0, 1'b0, 1'b0, 12'h5A3);
    mid_cycle_toggle();
    step(1'b1, 1'b1, 1'b1, '0);
    do_clear();

    // Random mix of loads and enable patterns
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom % 16;
      step(r != 0, ($urandom % 4) != 0, ($urandom % 4) != 0, W'($urandom));
      if (i % 97 == 50) do_clear();
      if (i % 61 == 30) mid_cycle_toggle();
    end

    // Long count to wrap
    step(1'b0, 1'b0, 1'b0, 12'hF00);
    for (int i = 0; i < 260; i++) step(1'b1, 1'b1, 1'b1, '0);

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule